// File: doc/BRIEF.md
# Card Function Interrupt Controller

This block owns the interrupt path of one function on a removable-card host interface. The function raises a service-request line. The block turns that request into a pending flag the host can read, and into an active-low signal on one of two host pins. One is the ordinary interrupt pin and the other is the status-change pin. The host picks the pin, picks pulse or level signalling, and can require an explicit acknowledge before the flag drops.

The host reaches the block through three byte-wide registers and one base register. The option register holds function enable, interrupt enable, pin routing, level/pulse mode, a hold-type soft reset, an explicit-base select and a two-bit index for a default I/O base. The status register holds the acknowledge-required bit, the pending flag and a power-down bit. The global register gives the host a pending view and a forwarding mask. Bus decoding and the function's own datapath sit outside the block.

Top module: `cfi_irq_ctrl`

## Requirements
- R1: After reset the option, status, global and base registers read 0, both host pins are high, and io_base_vld is 1 with io_base 0x300.
- R2: With acknowledge not required (status bit 0 = 0) and the interrupt active, the pending flag (status bit 1, mirrored in global bit 0) equals svc_req as sampled at the previous clock edge. Active means option bit 0 = 1, option bit 2 = 1, option bit 7 = 0 and status bit 2 = 0.
- R3: With status bit 0 = 1, a rising edge of svc_req sets the pending flag. The flag then holds until a status write with bit 1 = 1. A status write with bit 1 = 0 leaves it set, and a new rising edge in the same cycle as the clearing write wins over the clear.
- R4: In pulse mode (option bit 6 = 0), each 0-to-1 change of the pending flag drives the selected pin low for exactly PULSE_LEN clocks, even while svc_req stays high.
- R5: In level mode (option bit 6 = 1), the selected pin is low for exactly the cycles in which the pending flag is set.
- R6: Option bit 5 = 1 routes the interrupt to alt_irq_n, and 0 routes it to irq_n. The unselected pin stays high, and the two pins are never low together.
- R7: Global mask (global bit 1, written through glob_wr) = 1 keeps both pins high while the pending flag still sets and reads back. Clearing the mask lets a level-mode interrupt that is still pending reach the pin.
- R8: Option bit 7 = 1 holds the function in reset. func_rst is 1, func_en is 0, both pins are high, the pending flag clears by the next cycle and new requests are ignored. Writing the bit back to 0 releases the function.
- R9: Status bit 2 = 1 powers the function down. func_pd is 1, func_en is 0, both pins are high and the pending flag clears by the next cycle and stays clear.
- R10: With option bit 0 or option bit 2 at 0, requests do not set the pending flag.
- R11: With option bit 1 = 0, io_base is 0x300, 0x310 or 0x320 for option bits 4:3 = 0, 1 or 2. For bits 4:3 = 3, io_base_vld is 0 and io_base is 0. With option bit 1 = 1, io_base is the base register and io_base_vld is 1.
- R12: func_en is 1 exactly when option bit 0 = 1, option bit 7 = 0 and status bit 2 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_wr | input | 1 | Option register write strobe |
| opt_wdata | input | 8 | Option register write data |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 3 | Status write data: bit 0 ack-required, bit 1 clear pending (write 1), bit 2 power-down |
| glob_wr | input | 1 | Global mask write strobe |
| glob_wdata | input | 1 | New global mask value |
| base_wr | input | 1 | Explicit base register write strobe |
| base_wdata | input | BASE_W | Explicit base register write data |
| svc_req | input | 1 | Service request from the function |
| opt_q | output | 8 | Option register read value |
| stat_q | output | 8 | Status read value {00000, power-down, pending, ack-required} |
| glob_q | output | 8 | Global read value {000000, mask, pending} |
| io_base | output | BASE_W | Decoded I/O base |
| io_base_vld | output | 1 | I/O base decoded |
| func_en | output | 1 | Function enabled |
| func_rst | output | 1 | Function held in soft reset |
| func_pd | output | 1 | Function powered down |
| irq_n | output | 1 | Active-low interrupt pin |
| alt_irq_n | output | 1 | Active-low status-change pin |

## Verification
The bench builds the block with PULSE_LEN = 3 and BASE_W = 16. A length above one selects the down-counter variant of the pulse shaper. It also lets the bench tell an exact three-clock pulse apart from a one-clock strobe or a pulse that restarts while svc_req is held high. With a 16-bit base, the explicit base register can hold a value that matches none of the three default decodes, so the base select is observable on the io_base port.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
   // option register bit positions (host-visible encoding)
   localparam int OPT_FEN   = 0;
   localparam int OPT_BSEL  = 1;
   localparam int OPT_IEN   = 2;
   localparam int OPT_IDXLO = 3;
   localparam int OPT_ROUTE = 5;
   localparam int OPT_LVL   = 6;
   localparam int OPT_SRST  = 7;
   // status register bit positions
   localparam int ST_ACK  = 0;
   localparam int ST_PEND = 1;
   localparam int ST_PD   = 2;
   // base index value meaning "no default base"
   localparam logic [1:0] IDX_NONE = 2'd3;

   typedef struct packed {
      logic fen;
      logic ien;
      logic route_alt;
      logic lvl;
      logic srst;
      logic bsel;
      logic [1:0] idx;
   } opt_fields_t;

   function automatic opt_fields_t split_opt(input logic [7:0] v);
      opt_fields_t f;
      f.fen       = v[OPT_FEN];
      f.ien       = v[OPT_IEN];
      f.route_alt = v[OPT_ROUTE];
      f.lvl       = v[OPT_LVL];
      f.srst      = v[OPT_SRST];
      f.bsel      = v[OPT_BSEL];
      f.idx       = v[OPT_IDXLO +: 2];
      return f;
   endfunction
endpackage

// File: rtl/cfi_regs.sv
module cfi_regs #(
   parameter int BASE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              opt_wr,
   input  logic [7:0]        opt_wdata,
   input  logic              stat_wr,
   input  logic              stat_ack_wd,
   input  logic              stat_pd_wd,
   input  logic              glob_wr,
   input  logic              glob_wdata,
   input  logic              base_wr,
   input  logic [BASE_W-1:0] base_wdata,
   output logic [7:0]        opt_r,
   output logic              ack_r,
   output logic              pd_r,
   output logic              mask_r,
   output logic [BASE_W-1:0] base_r
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opt_r  <= '0;
         ack_r  <= 1'b0;
         pd_r   <= 1'b0;
         mask_r <= 1'b0;
         base_r <= '0;
      end else begin
         if (opt_wr) opt_r <= opt_wdata;
         if (stat_wr) begin
            ack_r <= stat_ack_wd;
            pd_r  <= stat_pd_wd;
         end
         if (glob_wr) mask_r <= glob_wdata;
         if (base_wr) base_r <= base_wdata;
      end
   end
endmodule

// File: rtl/cfi_pend.sv
module cfi_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic ack_mode,
   input  logic clr_req,
   input  logic svc_req,
   output logic pend_q,
   output logic pend_d
);
   logic svc_prev;
   logic svc_rise;

   assign svc_rise = svc_req & ~svc_prev;

   always_comb begin
      if (!active)
         pend_d = 1'b0;
      else if (ack_mode)
         pend_d = svc_rise | (pend_q & ~clr_req);
      else
         pend_d = svc_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_prev <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         svc_prev <= svc_req;
         pend_q   <= pend_d;
      end
   end
endmodule

// File: rtl/cfi_shaper.sv
module cfi_shaper #(
   parameter int PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fwd,
   input  logic lvl_mode,
   input  logic route_alt,
   input  logic pend_q,
   input  logic pend_d,
   output logic irq_n,
   output logic alt_irq_n
);
   localparam int CNT_W = $clog2(PULSE_LEN + 1);

   logic start;
   logic edge_on;
   logic hit;

   assign start = pend_d & ~pend_q & fwd;

   generate
      if (PULSE_LEN == 1) begin : g_strobe
         logic strobe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) strobe_q <= 1'b0;
            else        strobe_q <= start;
         end
         assign edge_on = strobe_q;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (!fwd)            cnt_q <= '0;
            else if (start)           cnt_q <= LOAD;
            else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
         end
         assign edge_on = (cnt_q != '0);
      end
   endgenerate

   assign hit       = fwd & (lvl_mode ? pend_q : edge_on);
   assign irq_n     = ~(hit & ~route_alt);
   assign alt_irq_n = ~(hit & route_alt);
endmodule

// File: rtl/cfi_irq_ctrl.sv
module cfi_irq_ctrl
   import cfi_pkg::*;
#(
   parameter int PULSE_LEN = 4,
   parameter int BASE_W    = 16,
   parameter int DEF_BASE  = 'h300,
   parameter int BASE_STEP = 'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              opt_wr,
   input  logic [7:0]        opt_wdata,
   input  logic              stat_wr,
   input  logic [2:0]        stat_wdata,
   input  logic              glob_wr,
   input  logic              glob_wdata,
   input  logic              base_wr,
   input  logic [BASE_W-1:0] base_wdata,
   input  logic              svc_req,
   output logic [7:0]        opt_q,
   output logic [7:0]        stat_q,
   output logic [7:0]        glob_q,
   output logic [BASE_W-1:0] io_base,
   output logic              io_base_vld,
   output logic              func_en,
   output logic              func_rst,
   output logic              func_pd,
   output logic              irq_n,
   output logic              alt_irq_n
);
   localparam logic [BASE_W-1:0] BASE0 = BASE_W'(DEF_BASE);
   localparam logic [BASE_W-1:0] STEP  = BASE_W'(BASE_STEP);

   generate
      if (PULSE_LEN < 1) begin : g_bad_len
         $error("PULSE_LEN must be at least 1");
      end
      if (BASE_W < 12 || BASE_W > 31) begin : g_bad_base
         $error("BASE_W must lie in 12..31");
      end
   endgenerate

   logic [7:0]        opt_r;
   logic              ack_r, pd_r, mask_r;
   logic [BASE_W-1:0] base_r;
   opt_fields_t       of;
   logic              active, fwd, pend_q, pend_d;

   cfi_regs #(.BASE_W(BASE_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .opt_wr(opt_wr), .opt_wdata(opt_wdata),
      .stat_wr(stat_wr), .stat_ack_wd(stat_wdata[ST_ACK]), .stat_pd_wd(stat_wdata[ST_PD]),
      .glob_wr(glob_wr), .glob_wdata(glob_wdata),
      .base_wr(base_wr), .base_wdata(base_wdata),
      .opt_r(opt_r), .ack_r(ack_r), .pd_r(pd_r), .mask_r(mask_r), .base_r(base_r)
   );

   assign of     = split_opt(opt_r);
   assign active = of.fen & of.ien & ~of.srst & ~pd_r;
   assign fwd    = active & ~mask_r;

   cfi_pend u_pend (
      .clk(clk), .rst_n(rst_n),
      .active(active), .ack_mode(ack_r),
      .clr_req(stat_wr & stat_wdata[ST_PEND]),
      .svc_req(svc_req),
      .pend_q(pend_q), .pend_d(pend_d)
   );

   cfi_shaper #(.PULSE_LEN(PULSE_LEN)) u_shape (
      .clk(clk), .rst_n(rst_n),
      .fwd(fwd), .lvl_mode(of.lvl), .route_alt(of.route_alt),
      .pend_q(pend_q), .pend_d(pend_d),
      .irq_n(irq_n), .alt_irq_n(alt_irq_n)
   );

   always_comb begin
      io_base_vld = 1'b1;
      if (of.bsel)
         io_base = base_r;
      else if (of.idx == IDX_NONE) begin
         io_base     = '0;
         io_base_vld = 1'b0;
      end else
         io_base = BASE0 + BASE_W'(of.idx) * STEP;
   end

   assign opt_q    = opt_r;
   assign stat_q   = {5'b0, pd_r, pend_q, ack_r};
   assign glob_q   = {6'b0, mask_r, pend_q};
   assign func_en  = of.fen & ~of.srst & ~pd_r;
   assign func_rst = of.srst;
   assign func_pd  = pd_r;
endmodule

// File: rtl/cfi_irq_ctrl_chk.sv
module cfi_irq_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fen,
   input logic       ien,
   input logic       srst,
   input logic [2:0] st,
   input logic       mask,
   input logic       stat_wr,
   input logic       stat_clr,
   input logic       irq_n,
   input logic       alt_irq_n
);
   // R6
   pins_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n || alt_irq_n);

   // R7
   mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask |-> (irq_n && alt_irq_n));

   // R8
   srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst |-> (irq_n && alt_irq_n));

   // R9
   pd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st[2] |=> !st[1]);

   // R3
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st[0] && st[1] && fen && ien && !srst && !st[2] && !(stat_wr && stat_clr))
      |=> st[1]);
endmodule

bind cfi_irq_ctrl cfi_irq_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .fen(opt_q[0]), .ien(opt_q[2]), .srst(opt_q[7]),
   .st(stat_q[2:0]), .mask(glob_q[1]),
   .stat_wr(stat_wr), .stat_clr(stat_wdata[1]),
   .irq_n(irq_n), .alt_irq_n(alt_irq_n)
);

// File: tb/test_cfi_irq_ctrl.sv
module test_cfi_irq_ctrl;
   localparam int CLK_P = 10;
   localparam int PLEN  = 3;
   localparam int WD    = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        opt_wr = 0, stat_wr = 0, glob_wr = 0, base_wr = 0, svc_req = 0;
   logic [7:0]  opt_wdata = 0;
   logic [2:0]  stat_wdata = 0;
   logic        glob_wdata = 0;
   logic [15:0] base_wdata = 0;
   logic [7:0]  opt_q, stat_q, glob_q;
   logic [15:0] io_base;
   logic        io_base_vld, func_en, func_rst, func_pd, irq_n, alt_irq_n;

   int    checks = 0, failures = 0;
   string cur_req = "R1";
   bit    cmp_on = 0;

   always #(CLK_P/2) clk = ~clk;

   cfi_irq_ctrl #(.PULSE_LEN(PLEN), .BASE_W(16)) i_cfi_irq_ctrl (
      .clk(clk), .rst_n(rst_n),
      .opt_wr(opt_wr), .opt_wdata(opt_wdata),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata),
      .glob_wr(glob_wr), .glob_wdata(glob_wdata),
      .base_wr(base_wr), .base_wdata(base_wdata),
      .svc_req(svc_req),
      .opt_q(opt_q), .stat_q(stat_q), .glob_q(glob_q),
      .io_base(io_base), .io_base_vld(io_base_vld),
      .func_en(func_en), .func_rst(func_rst), .func_pd(func_pd),
      .irq_n(irq_n), .alt_irq_n(alt_irq_n)
   );

   // behavioural reference model
   logic [7:0]  m_opt;
   logic [15:0] m_base;
   bit m_ack, m_pd, m_pend, m_mask, m_prev;
   int m_cnt;

   function automatic bit m_active();
      return m_opt[0] && m_opt[2] && !m_opt[7] && !m_pd;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_opt = 0; m_base = 0; m_ack = 0; m_pd = 0; m_pend = 0;
         m_mask = 0; m_prev = 0; m_cnt = 0;
      end else begin
         bit act, fw, np;
         int nc;
         act = m_active();
         fw  = act && !m_mask;
         if (!act) np = 0;
         else if (m_ack) begin
            if (svc_req && !m_prev) np = 1;
            else if (stat_wr && stat_wdata[1]) np = 0;
            else np = m_pend;
         end else np = svc_req;
         if (!fw) nc = 0;
         else if (np && !m_pend) nc = PLEN;
         else if (m_cnt > 0) nc = m_cnt - 1;
         else nc = 0;
         if (opt_wr) m_opt = opt_wdata;
         if (stat_wr) begin m_ack = stat_wdata[0]; m_pd = stat_wdata[2]; end
         if (glob_wr) m_mask = glob_wdata;
         if (base_wr) m_base = base_wdata;
         m_prev = svc_req; m_pend = np; m_cnt = nc;
      end
   end

   task automatic cmp(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         bit fw, asrt;
         logic [15:0] eb;
         bit ev;
         fw   = m_active() && !m_mask;
         asrt = fw && (m_opt[6] ? m_pend : (m_cnt > 0));
         ev = 1;
         if (m_opt[1]) eb = m_base;
         else if (m_opt[4:3] == 2'd3) begin eb = 0; ev = 0; end
         else eb = 16'h300 + 16'(m_opt[4:3]) * 16'h10;
         cmp("irq_n", irq_n, !(asrt && !m_opt[5]));
         cmp("alt_irq_n", alt_irq_n, !(asrt && m_opt[5]));
         cmp("stat_q", stat_q, {5'b0, m_pd, m_pend, m_ack});
         cmp("glob_q", glob_q, {6'b0, m_mask, m_pend});
         cmp("opt_q", opt_q, m_opt);
         cmp("io_base", io_base, eb);
         cmp("io_base_vld", io_base_vld, ev);
         cmp("func_en", func_en, m_opt[0] && !m_opt[7] && !m_pd);
         cmp("func_rst", func_rst, m_opt[7]);
         cmp("func_pd", func_pd, m_pd);
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic w_opt(logic [7:0] v);
      opt_wr = 1; opt_wdata = v; step(); opt_wr = 0;
   endtask
   task automatic w_stat(logic [2:0] v);
      stat_wr = 1; stat_wdata = v; step(); stat_wr = 0;
   endtask
   task automatic w_glob(logic v);
      glob_wr = 1; glob_wdata = v; step(); glob_wr = 0;
   endtask
   task automatic w_base(logic [15:0] v);
      base_wr = 1; base_wdata = v; step(); base_wr = 0;
   endtask

   // drive svc_req high for hi cycles, count low cycles on each pin
   task automatic run_svc(int hi, int total, output int li, output int la);
      li = 0; la = 0;
      for (int i = 0; i < total; i++) begin
         svc_req = (i < hi);
         @(negedge clk);
         if (!irq_n) li++;
         if (!alt_irq_n) la++;
         step();
      end
      svc_req = 0;
   endtask

   task automatic run_all();
      int li, la;
      repeat (3) step();
      rst_n = 1; cmp_on = 1;
      step();
      cur_req = "R1";
      cmp("reset stat", stat_q, 0); cmp("reset glob", glob_q, 0);
      cmp("reset pins", {irq_n, alt_irq_n}, 2'b11);
      cmp("reset base", io_base, 16'h300);

      cur_req = "R11";
      w_opt(8'h0D); cmp("idx1", io_base, 16'h310);
      w_opt(8'h15); cmp("idx2", io_base, 16'h320);
      w_opt(8'h1D); cmp("idx3 vld", io_base_vld, 0);
      w_base(16'h1234); w_opt(8'h07); cmp("explicit", io_base, 16'h1234);
      cur_req = "R12";
      w_opt(8'h05); cmp("func_en", func_en, 1);

      cur_req = "R4";
      run_svc(1, 8, li, la); cmp("pulse len", li, PLEN); cmp("other pin", la, 0);
      run_svc(7, 12, li, la); cmp("held req one pulse", li, PLEN);
      cur_req = "R2";
      svc_req = 1; step(); cmp("pend follows", stat_q[1], 1);
      svc_req = 0; step(); cmp("pend drops", stat_q[1], 0);

      cur_req = "R5";
      w_opt(8'h45); run_svc(5, 10, li, la); cmp("level len", li, 5);
      cur_req = "R6";
      w_opt(8'h65); run_svc(3, 8, li, la);
      cmp("alt len", la, 3); cmp("irq quiet", li, 0);
      w_opt(8'h25); run_svc(1, 8, li, la);
      cmp("alt pulse", la, PLEN); cmp("irq quiet pulse", li, 0);

      cur_req = "R3";
      w_opt(8'h45); w_stat(3'b001);
      run_svc(1, 8, li, la); cmp("ack held low", li, 7);
      cmp("ack pend", stat_q, 8'h03);
      w_stat(3'b001); step(); cmp("write0 ignored", stat_q, 8'h03);
      w_stat(3'b011); cmp("clear", stat_q, 8'h01); cmp("pin released", irq_n, 1);

      cur_req = "R7";
      w_glob(1); run_svc(1, 4, li, la);
      cmp("masked pins", li + la, 0); cmp("masked glob", glob_q, 8'h03);
      w_glob(0); cmp("unmasked pin", irq_n, 0);
      w_stat(3'b011); cmp("unmask clear", irq_n, 1);

      cur_req = "R8";
      run_svc(1, 3, li, la);
      w_opt(8'hC5); step();
      cmp("srst pend", stat_q, 8'h01); cmp("srst rst", func_rst, 1);
      cmp("srst en", func_en, 0); cmp("srst pin", irq_n, 1);
      run_svc(1, 4, li, la); cmp("srst ignore", stat_q, 8'h01);
      w_opt(8'h45); cmp("release", func_en, 1); cmp("release rst", func_rst, 0);

      cur_req = "R9";
      run_svc(1, 3, li, la);
      w_stat(3'b101); step();
      cmp("pd stat", stat_q, 8'h05); cmp("pd en", func_en, 0);
      cmp("pd pins", {irq_n, alt_irq_n}, 2'b11);
      run_svc(1, 4, li, la); cmp("pd ignore", stat_q, 8'h05);
      w_stat(3'b001); cmp("pd off", func_pd, 0);

      cur_req = "R10";
      w_opt(8'h41); run_svc(1, 4, li, la);
      cmp("no ien", stat_q[1], 0); cmp("no ien pin", li, 0);
      w_opt(8'h44); run_svc(1, 4, li, la); cmp("no fen", stat_q[1], 0);
      step();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (WD) @(posedge clk);
            failures++;
            $display("FAIL watchdog %s actual=timeout expected=done", cur_req);
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule